// File: doc/BRIEF.md
# Condition-Gated Execute and Branch-Link Unit

This block decides, one instruction per clock, whether the instruction at the current program counter takes effect, and it owns the program counter and the link register. Every instruction carries a 4-bit condition code. The code is tested against the four status flags: negative, zero, carry and overflow. A passing test lets the instruction act, and a failing test turns it into a no-op that only steps the PC by one word.

The instruction class selects what an executed instruction does to control flow. A plain instruction steps the PC by 4. A branch adds a signed 24-bit word offset, scaled by four, to the current PC. A branch-with-link does the same and also saves the following address (PC + 4) in the link register. A return loads the PC from the link register. The next-PC and link-write outputs are combinational from the inputs and state. The PC and the link register update on the next rising clock edge.

After reset the unit sits for one cycle in `ST_INIT` and then moves to `ST_RUN` (transition `INIT_TO_RUN`). In `ST_INIT` the PC is held and no instruction is accepted. In `ST_RUN` the unit stays in `ST_RUN` (transition `RUN_HOLD`) and handles one instruction per cycle.

Top module: `cx_branch_unit`

## Requirements
- R1: While reset is asserted, pc equals RESET_PC (default 0) and lr equals 0. In the first cycle after reset (ST_INIT), exec_en is 0, lr_we is 0 and pc does not change at the following edge, whatever the inputs are.
- R2: The flag input is ordered {N,Z,C,V} (bit 3 = N, bit 0 = V). The condition codes map as follows: 0 executes on Z=1, 1 on Z=0, 2 on C=1, 3 on C=0, 4 on N=1, 5 on N=0, 6 on V=1, 7 on V=0.
- R3: Code 8 executes when C=1 and Z=0. Code 9 executes when C=0 or Z=1.
- R4: Code 10 executes when N=V, code 11 when N!=V, code 12 when Z=0 and N=V, and code 13 when Z=1 or N!=V.
- R5: Code 14 always executes. Code 15 never executes, and rsv_cond is 1 in ST_RUN exactly when the code is 15.
- R6: An executed instruction of class 0 (plain) moves pc to pc+4 at the next edge and does not write lr.
- R7: An executed instruction of class 1 (branch) moves pc to pc + (sign-extended offset << 2), which covers offsets from -8388608 to +8388607 words, and it does not write lr.
- R8: An executed instruction of class 2 (branch-with-link) writes pc+4 into lr and moves pc to the same target as a branch.
- R9: An executed instruction of class 3 (return) moves pc to the current lr value and leaves lr unchanged.
- R10: An instruction whose condition fails, in any class, has exec_en 0 and lr_we 0. It moves pc to pc+4 and leaves lr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond | input | 4 | Condition code of the current instruction |
| flags | input | 4 | Status flags {N,Z,C,V} |
| iclass | input | 2 | 0 plain, 1 branch, 2 branch-with-link, 3 return |
| offset | input | 24 | Signed word offset for branches |
| exec_en | output | 1 | Instruction takes effect this cycle |
| rsv_cond | output | 1 | Reserved condition code seen |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Value pc takes at the next edge |
| lr_we | output | 1 | Link register write this cycle |
| lr_wdata | output | 32 | Value written to the link register |
| lr | output | 32 | Current link register |

## Verification
exec_en, rsv_cond, next_pc and lr_we are due in the same cycle the instruction is presented. The pc and lr registers show the result one edge later. For each instruction, the bench drives the inputs on a falling edge and samples the combinational outputs 1 ns later. It then waits for the rising edge and samples pc and lr 1 ns after it, comparing against a model updated by that one step. The ST_INIT cycle is checked separately: the bench verifies that pc holds across exactly one edge after reset is released.

// File: rtl/cx_pkg.sv
package cx_pkg;
    typedef enum logic [1:0] {
        IC_PLAIN  = 2'd0,
        IC_BRANCH = 2'd1,
        IC_BLINK  = 2'd2,
        IC_RETURN = 2'd3
    } iclass_t;

    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } cx_state_t;

    localparam int unsigned FLAG_N = 3;
    localparam int unsigned FLAG_Z = 2;
    localparam int unsigned FLAG_C = 1;
    localparam int unsigned FLAG_V = 0;

    localparam logic [3:0] CC_ALWAYS = 4'hE;
    localparam logic [3:0] CC_NEVER  = 4'hF;
endpackage

// File: rtl/cx_cond_eval.sv
// Condition test: codes 0..13 pair up as a base test and its inverse,
// selected by the low code bit; 14 and 15 are special.
module cx_cond_eval
    import cx_pkg::*;
#(
    parameter int unsigned CC_W = 4,
    parameter int unsigned FL_W = 4
) (
    input  logic [CC_W-1:0] cond,
    input  logic [FL_W-1:0] flags,
    output logic            pass,
    output logic            reserved
);
    localparam int unsigned NPAIRS = 7;

    logic n_f, z_f, c_f, v_f;
    logic [NPAIRS-1:0] base;

    assign n_f = flags[FLAG_N];
    assign z_f = flags[FLAG_Z];
    assign c_f = flags[FLAG_C];
    assign v_f = flags[FLAG_V];

    assign base[0] = z_f;
    assign base[1] = c_f;
    assign base[2] = n_f;
    assign base[3] = v_f;
    assign base[4] = c_f & ~z_f;
    assign base[5] = ~(n_f ^ v_f);
    assign base[6] = ~z_f & ~(n_f ^ v_f);

    logic [2*NPAIRS-1:0] per_code;

    genvar gi;
    generate
        for (gi = 0; gi < NPAIRS; gi++) begin : g_pair
            assign per_code[2*gi]   = base[gi];
            assign per_code[2*gi+1] = ~base[gi];
        end
    endgenerate

    always_comb begin
        reserved = (cond == CC_NEVER);
        if (cond == CC_ALWAYS)
            pass = 1'b1;
        else if (cond == CC_NEVER)
            pass = 1'b0;
        else
            pass = per_code[cond];
    end
endmodule

// File: rtl/cx_target.sv
// PC-relative target: sign-extend the word offset, scale by four, add.
module cx_target #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFF_W = 24
) (
    input  logic [XLEN-1:0]  base_pc,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  seq_pc
);
    localparam int unsigned EXT_W = XLEN - OFF_W - 2;

    logic [XLEN-1:0] byte_off;

    assign byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    assign target   = base_pc + byte_off;
    assign seq_pc   = base_pc + XLEN'(4);
endmodule

// File: rtl/cx_branch_unit.sv
module cx_branch_unit
    import cx_pkg::*;
#(
    parameter int unsigned    XLEN     = 32,
    parameter int unsigned    OFF_W    = 24,
    parameter logic [31:0]    RESET_PC = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cond,
    input  logic [3:0]       flags,
    input  logic [1:0]       iclass,
    input  logic [OFF_W-1:0] offset,
    output logic             exec_en,
    output logic             rsv_cond,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  next_pc,
    output logic             lr_we,
    output logic [XLEN-1:0]  lr_wdata,
    output logic [XLEN-1:0]  lr
);
    cx_state_t state_q, state_d;
    iclass_t   cls;
    logic      cc_pass, cc_rsv;
    logic [XLEN-1:0] tgt_pc, seq_pc;

    assign cls = iclass_t'(iclass);

    cx_cond_eval #(.CC_W(4), .FL_W(4)) u_cond (
        .cond    (cond),
        .flags   (flags),
        .pass    (cc_pass),
        .reserved(cc_rsv)
    );

    cx_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
        .base_pc(pc),
        .offset (offset),
        .target (tgt_pc),
        .seq_pc (seq_pc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_INIT;
        else
            state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        exec_en  = 1'b0;
        rsv_cond = 1'b0;
        next_pc  = pc;
        lr_we    = 1'b0;
        lr_wdata = seq_pc;
        unique case (state_q)
            ST_INIT: begin
                state_d = ST_RUN;           // INIT_TO_RUN
            end
            ST_RUN: begin
                state_d  = ST_RUN;          // RUN_HOLD
                exec_en  = cc_pass;
                rsv_cond = cc_rsv;
                if (!cc_pass) begin
                    next_pc = seq_pc;
                end else begin
                    unique case (cls)
                        IC_PLAIN:  next_pc = seq_pc;
                        IC_BRANCH: next_pc = tgt_pc;
                        IC_BLINK: begin
                            next_pc = tgt_pc;
                            lr_we   = 1'b1;
                        end
                        IC_RETURN: next_pc = lr;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= XLEN'(RESET_PC);
            lr <= '0;
        end else begin
            pc <= next_pc;
            if (lr_we)
                lr <= lr_wdata;
        end
    end
endmodule

// File: rtl/cx_branch_unit_chk.sv
module cx_branch_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      cond,
    input logic [1:0]      iclass,
    input logic            exec_en,
    input logic            rsv_cond,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] lr,
    input logic            lr_we
);
    logic run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    a_r1_init_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!exec_en && !lr_we));

    a_r5_always: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cond == 4'hE) |-> exec_en);

    a_r5_reserved_never: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_cond |-> !exec_en);

    a_r8_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && iclass == 2'd2) |=> (lr == $past(pc) + XLEN'(4)));

    a_r9_return_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && iclass == 2'd3) |=> (pc == $past(lr)));

    a_r10_fail_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !exec_en) |=> (pc == $past(pc) + XLEN'(4)));

    a_r10_lr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lr_we |=> $stable(lr));
endmodule

bind cx_branch_unit cx_branch_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (cond),
    .iclass  (iclass),
    .exec_en (exec_en),
    .rsv_cond(rsv_cond),
    .pc      (pc),
    .lr      (lr),
    .lr_we   (lr_we)
);

// File: tb/cx_branch_unit_bench.sv
`timescale 1ns/1ps
module cx_branch_unit_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  XLEN = 32;
    localparam int  OFF_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cond = 4'hE;
    logic [3:0] flags = 4'h0;
    logic [1:0] iclass = 2'd0;
    logic [OFF_W-1:0] offset = '0;
    logic exec_en, rsv_cond, lr_we;
    logic [XLEN-1:0] pc, next_pc, lr_wdata, lr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] m_pc, m_lr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cx_branch_unit #(.XLEN(XLEN), .OFF_W(OFF_W), .RESET_PC(32'h0)) u_cx_branch_unit (
        .clk(clk), .rst_n(rst_n), .cond(cond), .flags(flags), .iclass(iclass),
        .offset(offset), .exec_en(exec_en), .rsv_cond(rsv_cond), .pc(pc),
        .next_pc(next_pc), .lr_we(lr_we), .lr_wdata(lr_wdata), .lr(lr)
    );

    function automatic bit exp_pass(input logic [3:0] c, input logic [3:0] f);
        bit n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        if (c <= 4'd7) return "R2";
        if (c <= 4'd9) return "R3";
        if (c <= 4'd13) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] c, input logic [3:0] f, input logic [1:0] k, input logic [23:0] o);
        bit p;
        logic [31:0] tgt, e_pc, e_lr;
        string rq;
        @(negedge clk);
        cond = c; flags = f; iclass = k; offset = o;
        #1;
        p = exp_pass(c, f);
        chk(req_of(c), "exec_en", {31'd0, exec_en}, {31'd0, p});
        chk("R5", "rsv_cond", {31'd0, rsv_cond}, {31'd0, c == 4'hF});
        tgt = m_pc + {{6{o[23]}}, o, 2'b00};
        e_lr = m_lr;
        if (!p) begin e_pc = m_pc + 4; rq = "R10"; end
        else if (k == 2'd0) begin e_pc = m_pc + 4; rq = "R6"; end
        else if (k == 2'd1) begin e_pc = tgt; rq = "R7"; end
        else if (k == 2'd2) begin e_pc = tgt; e_lr = m_pc + 4; rq = "R8"; end
        else begin e_pc = m_lr; rq = "R9"; end
        chk(rq, "lr_we", {31'd0, lr_we}, {31'd0, p && k == 2'd2});
        @(posedge clk);
        #1;
        chk(rq, "pc", pc, e_pc);
        chk(rq, "lr", lr, e_lr);
        m_pc = e_pc;
        m_lr = e_lr;
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240917));
        m_pc = 32'h0;
        m_lr = 32'h0;
        repeat (3) @(negedge clk);
        chk("R1", "reset pc", pc, 32'h0);
        chk("R1", "reset lr", lr, 32'h0);
        cond = 4'hE; iclass = 2'd2; offset = 24'h000100;
        rst_n = 1'b1;
        #1;
        chk("R1", "init exec_en", {31'd0, exec_en}, 32'd0);
        chk("R1", "init lr_we", {31'd0, lr_we}, 32'd0);
        @(posedge clk); #1;
        chk("R1", "init pc hold", pc, 32'h0);
        chk("R1", "init lr hold", lr, 32'h0);

        // directed: every code against all 16 flag patterns, plain class
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                step(4'(c), 4'(f), 2'd0, 24'd0);

        // branch reach extremes
        step(4'hE, 4'h0, 2'd1, 24'h7FFFFF);
        step(4'hE, 4'h0, 2'd1, 24'h800000);
        // link then return
        step(4'hE, 4'h0, 2'd2, 24'h000040);
        step(4'hE, 4'h0, 2'd0, 24'd0);
        step(4'hE, 4'h0, 2'd3, 24'd0);
        // failed link and failed return leave lr and step pc
        step(4'h0, 4'h0, 2'd2, 24'h000010);
        step(4'hF, 4'hF, 2'd3, 24'd0);
        // backward branch by one word
        step(4'h1, 4'h0, 2'd1, 24'hFFFFFF);

        for (int i = 0; i < 600; i++)
            step(4'($urandom_range(15)), 4'($urandom_range(15)),
                 2'($urandom_range(3)), 24'($urandom));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule